// File: doc/BRIEF.md
# Board Controller Register File

This block is the control and status register set of a small evaluation board. A host reaches it through a simple 32-bit bus port with a request strobe, a write flag, an address and write data. Behind that port sit an 8-bit LED register that drives the board LEDs directly, a break-character register and an 8-bit general-purpose output register.

Four further registers let software drive an I2C bus by hand. Writing the output register puts a new SCL/SDA pair on the pins that go to an attached slave, such as a serial EEPROM. Reading the input register returns a stored value whose bit 0 is replaced by the SDA level the slave is driving at that moment. An output-enable register and a select register hold configuration bits that software can read back.

Reads take one cycle. Unmapped offsets read as zero, and writes to them are dropped.

Top module: `board_ctrl`

## Requirements
- R1: After reset the registers read LED 0x00, break 0x0A, general-purpose 0x00, I2C output-enable 0x0, I2C output 0x3 and I2C select 0x1. The I2C input register reads 0x2 with bit 0 set to the live slave SDA. The LED pins are all low and both the SCL and SDA pins are high.
- R2: The LED register is at offset 0x100 and keeps only write bits 7:0. From the cycle after the write, LED pin i equals register bit i.
- R3: The break register is at offset 0x200 and keeps only write bits 7:0.
- R4: The general-purpose output register is at offset 0xA00 and keeps only write bits 7:0.
- R5: The I2C input register is at offset 0xB00. A read returns the stored value 0x3 with bit 0 replaced by the level on the slave SDA input, sampled in the request cycle. Writes to this offset change nothing.
- R6: The I2C output-enable register is at offset 0xB08 and keeps only write bits 1:0.
- R7: The I2C output register is at offset 0xB10. Write bit 1 is SCL and bit 0 is SDA. Both pins take the written levels from the cycle after the write and otherwise hold steady. A read returns the two stored bits.
- R8: The I2C select register is at offset 0xB18, keeps only write bit 0 and reads back its own value.
- R9: Reads of any other offset return zero. Writes to any other offset leave every register and output unchanged.
- R10: Read data and the read-valid flag appear in the cycle after a read request. The read-valid flag is low in every other cycle, including the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_req_i | input | 1 | Bus access request for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| bus_rvalid_o | output | 1 | High for one cycle when bus_rdata_o holds a read result |
| led_o | output | 8 | LED drive, one bit per LED |
| i2c_scl_o | output | 1 | SCL level driven to the slave |
| i2c_sda_o | output | 1 | SDA level driven to the slave |
| i2c_sda_i | input | 1 | SDA level returned by the slave |

## Verification
Every register update and every pin change caused by a write shows up exactly one clock after the edge that accepts the write. Read data and its valid flag are also due one clock after the request edge. The bench drives each request at a falling edge, drops it at the next falling edge and samples outputs only at that second falling edge, half a period after the result is registered. The live SDA bit is held stable across the request cycle, so the sampled value is known. Writes to unmapped or read-only offsets are checked by reading every register and pin again before any further write.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

    localparam int LED_W  = 8;
    localparam int BYTE_W = 8;
    localparam int I2C_W  = 2;
    localparam int OFF_W  = 32;

    localparam logic [OFF_W-1:0] OFF_LED     = 32'h0000_0100;
    localparam logic [OFF_W-1:0] OFF_BRK     = 32'h0000_0200;
    localparam logic [OFF_W-1:0] OFF_GPO     = 32'h0000_0A00;
    localparam logic [OFF_W-1:0] OFF_I2C_IN  = 32'h0000_0B00;
    localparam logic [OFF_W-1:0] OFF_I2C_OE  = 32'h0000_0B08;
    localparam logic [OFF_W-1:0] OFF_I2C_OUT = 32'h0000_0B10;
    localparam logic [OFF_W-1:0] OFF_I2C_SEL = 32'h0000_0B18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LED,
        SEL_BRK,
        SEL_GPO,
        SEL_I2C_IN,
        SEL_I2C_OE,
        SEL_I2C_OUT,
        SEL_I2C_SEL
    } reg_sel_e;

    typedef struct packed {
        logic [LED_W-1:0]  led;
        logic [BYTE_W-1:0] brk;
        logic [BYTE_W-1:0] gpo;
        logic [I2C_W-1:0]  i2c_in;
        logic [I2C_W-1:0]  i2c_oe;
        logic [I2C_W-1:0]  i2c_out;
        logic              i2c_sel;
    } ctrl_regs_t;

    localparam ctrl_regs_t REGS_RESET = '{
        led:     '0,
        brk:     8'h0A,
        gpo:     '0,
        i2c_in:  2'h3,
        i2c_oe:  2'h0,
        i2c_out: 2'h3,
        i2c_sel: 1'b1
    };

    function automatic reg_sel_e decode_offset(input logic [OFF_W-1:0] off);
        reg_sel_e s;
        case (off)
            OFF_LED:     s = SEL_LED;
            OFF_BRK:     s = SEL_BRK;
            OFF_GPO:     s = SEL_GPO;
            OFF_I2C_IN:  s = SEL_I2C_IN;
            OFF_I2C_OE:  s = SEL_I2C_OE;
            OFF_I2C_OUT: s = SEL_I2C_OUT;
            OFF_I2C_SEL: s = SEL_I2C_SEL;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [OFF_W-1:0] read_word(input reg_sel_e s,
                                                   input ctrl_regs_t r,
                                                   input logic sda_live);
        logic [OFF_W-1:0] w;
        w = '0;
        case (s)
            SEL_LED:     w[LED_W-1:0]  = r.led;
            SEL_BRK:     w[BYTE_W-1:0] = r.brk;
            SEL_GPO:     w[BYTE_W-1:0] = r.gpo;
            SEL_I2C_IN:  w[I2C_W-1:0]  = {r.i2c_in[I2C_W-1:1], sda_live};
            SEL_I2C_OE:  w[I2C_W-1:0]  = r.i2c_oe;
            SEL_I2C_OUT: w[I2C_W-1:0]  = r.i2c_out;
            SEL_I2C_SEL: w[0]          = r.i2c_sel;
            default:     w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/bc_decode.sv
module bc_decode
    import board_ctrl_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    localparam int PAD_W = OFF_W - ADDR_W;

    logic [OFF_W-1:0] off_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign off_ext = {{PAD_W{1'b0}}, addr_i};
        end else begin : g_nopad
            assign off_ext = addr_i[OFF_W-1:0];
        end
    endgenerate

    always_comb begin
        sel_o = decode_offset(off_ext);
    end

endmodule

// File: rtl/bc_reg_bank.sv
module bc_reg_bank
    import board_ctrl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ctrl_regs_t        regs_o
);

    ctrl_regs_t regs_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            regs_q <= REGS_RESET;
        end else if (wr_en_i) begin
            case (sel_i)
                SEL_LED:     regs_q.led     <= wdata_i[LED_W-1:0];
                SEL_BRK:     regs_q.brk     <= wdata_i[BYTE_W-1:0];
                SEL_GPO:     regs_q.gpo     <= wdata_i[BYTE_W-1:0];
                SEL_I2C_OE:  regs_q.i2c_oe  <= wdata_i[I2C_W-1:0];
                SEL_I2C_OUT: regs_q.i2c_out <= wdata_i[I2C_W-1:0];
                SEL_I2C_SEL: regs_q.i2c_sel <= wdata_i[0];
                default:     regs_q         <= regs_q;
            endcase
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/bc_read_port.sv
module bc_read_port
    import board_ctrl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rd_en_i,
    input  reg_sel_e          sel_i,
    input  ctrl_regs_t        regs_i,
    input  logic              sda_live_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    logic [OFF_W-1:0]  word;
    logic [DATA_W-1:0] word_fit;

    always_comb begin
        word = read_word(sel_i, regs_i, sda_live_i);
    end

    generate
        if (DATA_W >= OFF_W) begin : g_wide
            assign word_fit = DATA_W'(word);
        end else begin : g_narrow
            assign word_fit = word[DATA_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_en_i;
            if (rd_en_i) begin
                rdata_o <= word_fit;
            end
        end
    end

endmodule

// File: rtl/board_ctrl.sv
module board_ctrl
    import board_ctrl_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic [LED_W-1:0]  led_o,
    output logic              i2c_scl_o,
    output logic              i2c_sda_o,
    input  logic              i2c_sda_i
);

    reg_sel_e   sel;
    ctrl_regs_t regs;
    logic       wr_en;
    logic       rd_en;

    assign wr_en = bus_req_i & bus_we_i;
    assign rd_en = bus_req_i & ~bus_we_i;

    bc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    bc_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_en_i (wr_en),
        .sel_i   (sel),
        .wdata_i (bus_wdata_i),
        .regs_o  (regs)
    );

    bc_read_port #(.DATA_W(DATA_W)) u_rport (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .rd_en_i    (rd_en),
        .sel_i      (sel),
        .regs_i     (regs),
        .sda_live_i (i2c_sda_i),
        .rdata_o    (bus_rdata_o),
        .rvalid_o   (bus_rvalid_o)
    );

    generate
        for (genvar i = 0; i < LED_W; i++) begin : g_led
            assign led_o[i] = regs.led[i];
        end
    endgenerate

    assign i2c_scl_o = regs.i2c_out[1];
    assign i2c_sda_o = regs.i2c_out[0];

endmodule

// File: rtl/board_ctrl_chk.sv
module board_ctrl_chk
    import board_ctrl_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              bus_req_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              bus_rvalid_o,
    input logic [LED_W-1:0]  led_o,
    input logic              i2c_scl_o,
    input logic              i2c_sda_o,
    input logic              i2c_sda_i
);

    logic rd_req, wr_req, hit_out, hit_led, hit_in, hit_any;

    assign rd_req  = bus_req_i & ~bus_we_i;
    assign wr_req  = bus_req_i & bus_we_i;
    assign hit_out = (OFF_W'(bus_addr_i) == OFF_I2C_OUT);
    assign hit_led = (OFF_W'(bus_addr_i) == OFF_LED);
    assign hit_in  = (OFF_W'(bus_addr_i) == OFF_I2C_IN);
    assign hit_any = hit_out | hit_led | hit_in
                   | (OFF_W'(bus_addr_i) == OFF_BRK)
                   | (OFF_W'(bus_addr_i) == OFF_GPO)
                   | (OFF_W'(bus_addr_i) == OFF_I2C_OE)
                   | (OFF_W'(bus_addr_i) == OFF_I2C_SEL);

    // R10
    rvalid_after_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_req |=> bus_rvalid_o);

    // R10
    rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_req |=> !bus_rvalid_o);

    // R7
    i2c_pins_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_req && hit_out) |=> (i2c_scl_o == $past(bus_wdata_i[1]))
                             && (i2c_sda_o == $past(bus_wdata_i[0])));

    // R7
    i2c_pins_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_req && hit_out) |=> $stable(i2c_scl_o) && $stable(i2c_sda_o));

    // R2
    led_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_req && hit_led) |=> (led_o == $past(bus_wdata_i[LED_W-1:0])));

    // R5
    sda_live_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_req && hit_in) |=> (bus_rdata_o[0] == $past(i2c_sda_i)));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_req && !hit_any) |=> (bus_rdata_o == '0));

endmodule

bind board_ctrl board_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/board_ctrl_bench.sv
module board_ctrl_bench;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam int NVEC   = 21;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic              we  = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              rvalid;
    logic [7:0]        leds;
    logic              scl, sda;
    logic              sda_in = 1'b1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    board_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_board_ctrl (
        .clk_i(clk), .rst_i(rst), .bus_req_i(req), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .bus_rvalid_o(rvalid), .led_o(leds), .i2c_scl_o(scl),
        .i2c_sda_o(sda), .i2c_sda_i(sda_in)
    );

    // {is_read, req_no[3:0], addr[19:0], data[31:0]}; data = wdata or expected
    localparam logic [56:0] VEC [0:NVEC-1] = '{
        {1'b0, 4'd2,  20'h00100, 32'hFFFF_FFA5},  // R2 write
        {1'b1, 4'd2,  20'h00100, 32'h0000_00A5},  // R2 read
        {1'b0, 4'd3,  20'h00200, 32'h1234_5678},  // R3 write
        {1'b1, 4'd3,  20'h00200, 32'h0000_0078},  // R3 read
        {1'b0, 4'd4,  20'h00A00, 32'hABCD_EF3C},  // R4 write
        {1'b1, 4'd4,  20'h00A00, 32'h0000_003C},  // R4 read
        {1'b0, 4'd6,  20'h00B08, 32'hFFFF_FFFF},  // R6 write
        {1'b1, 4'd6,  20'h00B08, 32'h0000_0003},  // R6 read
        {1'b0, 4'd7,  20'h00B10, 32'hFFFF_FFFE},  // R7 write
        {1'b1, 4'd7,  20'h00B10, 32'h0000_0002},  // R7 read
        {1'b0, 4'd8,  20'h00B18, 32'hFFFF_FFF0},  // R8 write 0
        {1'b1, 4'd8,  20'h00B18, 32'h0000_0000},  // R8 read
        {1'b0, 4'd8,  20'h00B18, 32'h0000_0003},  // R8 write 1
        {1'b1, 4'd8,  20'h00B18, 32'h0000_0001},  // R8 read
        {1'b0, 4'd5,  20'h00B00, 32'h0000_0000},  // R5 write ignored
        {1'b1, 4'd5,  20'h00B00, 32'h0000_0003},  // R5 read, sda_in=1
        {1'b0, 4'd9,  20'h00104, 32'hFFFF_FFFF},  // R9 unmapped write
        {1'b1, 4'd9,  20'h00104, 32'h0000_0000},  // R9 unmapped read
        {1'b1, 4'd9,  20'h00100, 32'h0000_00A5},  // R9 LED untouched
        {1'b1, 4'd9,  20'h00B04, 32'h0000_0000},  // R9 gap read
        {1'b1, 4'd9,  20'h00B1C, 32'h0000_0000}   // R9 past last register
    };

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                            output logic v);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        d = rdata; v = rvalid;
    endtask

    task automatic read_expect(input string tag, input logic [ADDR_W-1:0] a,
                               input logic [31:0] exp);
        logic [DATA_W-1:0] d;
        logic v;
        bus_read(a, d, v);
        check(tag, d, exp, $sformatf("read @%h", a));
        check("R10", {31'd0, v}, 32'd1, "rvalid after read");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        sda_in = 1'b1;
        do_reset();
        // R1 reset state at the ports and through reads
        check("R1", {24'd0, leds}, 32'h0, "leds after reset");
        check("R1", {30'd0, scl, sda}, 32'h3, "scl/sda after reset");
        check("R10", {31'd0, rvalid}, 32'h0, "rvalid idle after reset");
        read_expect("R1", 20'h00100, 32'h00);
        read_expect("R1", 20'h00200, 32'h0A);
        read_expect("R1", 20'h00A00, 32'h00);
        read_expect("R1", 20'h00B00, 32'h3);
        read_expect("R1", 20'h00B08, 32'h0);
        read_expect("R1", 20'h00B10, 32'h3);
        read_expect("R1", 20'h00B18, 32'h1);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][56]) begin
                read_expect($sformatf("R%0d", VEC[i][55:52]), VEC[i][51:32], VEC[i][31:0]);
            end else begin
                bus_write(VEC[i][51:32], VEC[i][31:0]);
            end
        end

        // R5 live SDA: slave pulls low, then releases
        sda_in = 1'b0;
        read_expect("R5", 20'h00B00, 32'h2);
        sda_in = 1'b1;
        read_expect("R5", 20'h00B00, 32'h3);

        // R7 pins follow writes; pattern 0b10 left from table
        check("R7", {30'd0, scl, sda}, 32'h2, "pins after table write");
        bus_write(20'h00B10, 32'h1);
        check("R7", {30'd0, scl, sda}, 32'h1, "scl low sda high");
        bus_write(20'h00B10, 32'h0);
        check("R7", {30'd0, scl, sda}, 32'h0, "both low");
        bus_write(20'h00B10, 32'h3);
        check("R7", {30'd0, scl, sda}, 32'h3, "both high");

        // R2 LED pins
        bus_write(20'h00100, 32'h0000_0181);
        check("R2", {24'd0, leds}, 32'h81, "led pins");
        check("R10", {31'd0, rvalid}, 32'h0, "rvalid low after write");

        // R9 writes near mapped offsets change nothing
        bus_write(20'h00B0C, 32'h0);
        bus_write(20'h00A04, 32'hFF);
        bus_write(20'h80100, 32'h0);
        check("R9", {24'd0, leds}, 32'h81, "leds after unmapped writes");
        check("R9", {30'd0, scl, sda}, 32'h3, "pins after unmapped writes");
        read_expect("R9", 20'h00100, 32'h81);
        read_expect("R9", 20'h00A00, 32'h3C);
        read_expect("R9", 20'h00B08, 32'h3);
        read_expect("R9", 20'h80100, 32'h0);

        // R1 reset mid-run restores defaults
        do_reset();
        check("R1", {24'd0, leds}, 32'h0, "leds after second reset");
        read_expect("R1", 20'h00200, 32'h0A);
        read_expect("R1", 20'h00B18, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule